// File: doc/BRIEF.md
# Runtime-Partitioned Packed Integer ALU

This unit performs integer arithmetic on a single 128-bit word that is split, cycle by cycle, into equal lanes of 16, 32 or 64 bits. A two-bit width selector picks the lane size. A two-bit operation code picks the operation, and that operation is applied to every lane at once. The lanes are fully independent: no carry, borrow or partial product crosses from one lane into the next.

The unit is pipelined with a fixed latency of two cycles and accepts a new operation on every clock. A valid strobe travels through the pipeline alongside the data. A reserved width code returns an all-zero word and raises an error flag with the result.

Top module: `simd_lane_alu`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `out_valid`, `mode_err` and `result` are all zero.
- R2: `out_valid` equals `in_valid` delayed by exactly two clock cycles. Operations may be issued on consecutive cycles with no gap.
- R3: With opcode 2'b00, each lane returns (A + B) mod 2^N. Width code 2'b00 gives N=16, 2'b01 gives N=32 and 2'b10 gives N=64. Lane i occupies bits [i*N+N-1 : i*N].
- R4: A carry out of the top of any lane does not reach the next lane. In 16-bit mode, 0xFFFF + 0x0001 in lane 0 gives 0x0000 there and leaves lane 1 equal to the sum of its own operands.
- R5: With opcode 2'b01, each lane returns (A - B) mod 2^N, and a borrow never propagates into a neighbouring lane.
- R6: With opcode 2'b10, each lane returns the low N bits of the N-by-N lane product, formed only from that lane's operand bits.
- R7: With opcode 2'b11 and a valid width code, the result equals operand A unchanged.
- R8: Width code 2'b11 gives an all-zero result with `mode_err` set for that operation, whatever the opcode. For valid width codes, `mode_err` is low.
- R9: Width and opcode may change on every issued operation, and each result reflects only the settings issued with its own operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation issue strobe |
| width_sel | input | 2 | Lane width: 00=16, 01=32, 10=64, 11=reserved |
| opcode | input | 2 | 00 add, 01 subtract, 10 multiply-low, 11 pass A |
| opa | input | 128 | Operand A, packed lanes |
| opb | input | 128 | Operand B, packed lanes |
| out_valid | output | 1 | Result strobe, two cycles after issue |
| result | output | 128 | Packed lane results |
| mode_err | output | 1 | Reserved width code was issued with this result |

## Verification
On every cycle, the assertions check the two-stage travel of the valid strobe, the zero result when the error flag is raised, the pass-through path, and the lowest 16-bit lane sum. Lane-boundary isolation for add, subtract and multiply in all three widths can only be shown by the bench's directed carry, borrow and overflow patterns and its random stream. The same holds for the correct pairing of settings with operands when width and opcode change on consecutive cycles.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  localparam logic [1:0] LW16   = 2'b00;
  localparam logic [1:0] LW32   = 2'b01;
  localparam logic [1:0] LW64   = 2'b10;
  localparam logic [1:0] LW_RSV = 2'b11;

  localparam logic [1:0] OP_ADD   = 2'b00;
  localparam logic [1:0] OP_SUB   = 2'b01;
  localparam logic [1:0] OP_MULLO = 2'b10;
  localparam logic [1:0] OP_PASS  = 2'b11;
endpackage

// File: rtl/seg_addsub.sv
module seg_addsub #(
  parameter int DATA_W  = 128,
  parameter int CHUNK_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic [1:0]        width_sel,
  output logic [DATA_W-1:0] sum
);
  localparam int NCHUNK = DATA_W / CHUNK_W;

  logic [2:0]        per_mask;
  logic [NCHUNK-1:0] lane_start;
  logic [DATA_W-1:0] b_eff;

  // a chunk begins a lane when its index is a multiple of the chunks per lane
  always_comb begin
    per_mask = (3'd1 << width_sel) - 3'd1;
    for (int k = 0; k < NCHUNK; k++) begin
      lane_start[k] = ((3'(k) & per_mask) == 3'd0);
    end
  end

  assign b_eff = sub ? ~b : b;

  always_comb begin
    logic              c;
    logic [CHUNK_W:0]  t;
    c   = 1'b0;
    t   = '0;
    sum = '0;
    for (int k = 0; k < NCHUNK; k++) begin
      if (lane_start[k]) c = sub;  // cut the carry chain at every lane edge
      t = {1'b0, a[k*CHUNK_W +: CHUNK_W]} + {1'b0, b_eff[k*CHUNK_W +: CHUNK_W]}
          + {{CHUNK_W{1'b0}}, c};
      sum[k*CHUNK_W +: CHUNK_W] = t[CHUNK_W-1:0];
      c = t[CHUNK_W];
    end
  end
endmodule

// File: rtl/seg_mullo.sv
module seg_mullo #(
  parameter int DATA_W  = 128,
  parameter int CHUNK_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [1:0]        width_sel,
  output logic [DATA_W-1:0] prod
);
  localparam int NWIDTH = 3;

  logic [NWIDTH-1:0][DATA_W-1:0] prod_w;

  genvar m, i;
  generate
    for (m = 0; m < NWIDTH; m++) begin : g_width
      localparam int LW = CHUNK_W << m;
      localparam int NL = DATA_W / LW;
      for (i = 0; i < NL; i++) begin : g_lane
        assign prod_w[m][i*LW +: LW] = a[i*LW +: LW] * b[i*LW +: LW];
      end
    end
  endgenerate

  always_comb begin
    case (width_sel)
      2'b00:   prod = prod_w[0];
      2'b01:   prod = prod_w[1];
      2'b10:   prod = prod_w[2];
      default: prod = '0;
    endcase
  end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_alu_pkg::*;
#(
  parameter int DATA_W  = 128,
  parameter int CHUNK_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        width_sel,
  input  logic [1:0]        opcode,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              mode_err
);
  // stage 1: operand capture
  logic              s1_valid;
  logic [1:0]        s1_wsel;
  logic [1:0]        s1_op;
  logic [DATA_W-1:0] s1_a;
  logic [DATA_W-1:0] s1_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_wsel  <= LW16;
      s1_op    <= OP_ADD;
      s1_a     <= '0;
      s1_b     <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_wsel  <= width_sel;
      s1_op    <= opcode;
      s1_a     <= opa;
      s1_b     <= opb;
    end
  end

  // stage 2: lane arithmetic
  logic [DATA_W-1:0] sum_w;
  logic [DATA_W-1:0] prod_w;
  logic [DATA_W-1:0] res_next;
  logic              rsv_width;

  seg_addsub #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W)) i_addsub (
    .a(s1_a), .b(s1_b), .sub(s1_op == OP_SUB), .width_sel(s1_wsel), .sum(sum_w)
  );

  seg_mullo #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W)) i_mullo (
    .a(s1_a), .b(s1_b), .width_sel(s1_wsel), .prod(prod_w)
  );

  assign rsv_width = (s1_wsel == LW_RSV);

  always_comb begin
    if (rsv_width) res_next = '0;
    else begin
      case (s1_op)
        OP_ADD, OP_SUB: res_next = sum_w;
        OP_MULLO:       res_next = prod_w;
        default:        res_next = s1_a;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      mode_err  <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      result    <= res_next;
      mode_err  <= s1_valid & rsv_width;
    end
  end

  // the strobe moves one stage per clock
  assert_valid_stage1_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> s1_valid);
  assert_valid_stage2_R2: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> out_valid);
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> !out_valid);
  assert_err_zero_R8: assert property (@(posedge clk) disable iff (rst)
    mode_err |-> (out_valid && result == '0));
  assert_pass_a_R7: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_op == OP_PASS && !rsv_width) |=> (result == $past(s1_a)));
  assert_lane0_add_R3: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_op == OP_ADD && s1_wsel == LW16)
      |=> (result[CHUNK_W-1:0] == $past(s1_a[CHUNK_W-1:0] + s1_b[CHUNK_W-1:0])));
endmodule

// File: tb/test_simd_lane_alu.sv
`timescale 1ns/1ps
module test_simd_lane_alu;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [1:0]   width_sel;
  logic [1:0]   opcode;
  logic [127:0] opa;
  logic [127:0] opb;
  logic         out_valid;
  logic [127:0] result;
  logic         mode_err;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  simd_lane_alu i_simd_lane_alu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .width_sel(width_sel),
    .opcode(opcode), .opa(opa), .opb(opb), .out_valid(out_valid),
    .result(result), .mode_err(mode_err)
  );

  // issue history, index 1 is the operation whose result is due now
  logic         h_v[2];
  logic [1:0]   h_m[2];
  logic [1:0]   h_o[2];
  logic [127:0] h_a[2];
  logic [127:0] h_b[2];
  string        h_tag[2];

  function automatic logic [128:0] ref_op(input logic [1:0] m, input logic [1:0] o,
                                          input logic [127:0] a, input logic [127:0] b);
    logic [127:0] res, mask, la, lb, r;
    int n;
    if (m == 2'b11) return {1'b1, 128'd0};
    if (o == 2'b11) return {1'b0, a};
    n = 16 << m;
    mask = (128'd1 << n) - 128'd1;
    res = '0;
    for (int i = 0; i < 128 / n; i++) begin
      la = (a >> (i * n)) & mask;
      lb = (b >> (i * n)) & mask;
      case (o)
        2'b00:   r = la + lb;
        2'b01:   r = la - lb;
        default: r = la * lb;
      endcase
      res = res | ((r & mask) << (i * n));
    end
    return {1'b0, res};
  endfunction

  task automatic check_out();
    logic [128:0] e;
    tests++;
    if (out_valid !== h_v[1]) begin
      fails++;
      $display("FAIL R2 out_valid actual=%b expected=%b", out_valid, h_v[1]);
    end
    if (h_v[1]) begin
      e = ref_op(h_m[1], h_o[1], h_a[1], h_b[1]);
      tests++;
      if (result !== e[127:0] || mode_err !== e[128]) begin
        fails++;
        $display("FAIL %s m=%0d op=%0d actual=%h err=%b expected=%h err=%b",
                 h_tag[1], h_m[1], h_o[1], result, mode_err, e[127:0], e[128]);
      end
    end
  endtask

  task automatic issue(input logic v, input logic [1:0] m, input logic [1:0] o,
                       input logic [127:0] a, input logic [127:0] b, input string tag);
    @(negedge clk);
    check_out();
    h_v[1] = h_v[0]; h_m[1] = h_m[0]; h_o[1] = h_o[0];
    h_a[1] = h_a[0]; h_b[1] = h_b[0]; h_tag[1] = h_tag[0];
    h_v[0] = v; h_m[0] = m; h_o[0] = o; h_a[0] = a; h_b[0] = b; h_tag[0] = tag;
    in_valid = v; width_sel = m; opcode = o; opa = a; opb = b;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [127:0] ra, rb;
    void'($urandom(32'h5EED_2024));
    rst = 1'b1; in_valid = 1'b0; width_sel = 2'b00; opcode = 2'b00; opa = '0; opb = '0;
    for (int i = 0; i < 2; i++) begin
      h_v[i] = 1'b0; h_m[i] = '0; h_o[i] = '0; h_a[i] = '0; h_b[i] = '0; h_tag[i] = "";
    end
    repeat (3) @(negedge clk);
    tests++;
    if (out_valid !== 1'b0 || result !== '0 || mode_err !== 1'b0) begin
      fails++;
      $display("FAIL R1 in reset actual v=%b r=%h e=%b expected 0", out_valid, result, mode_err);
    end
    rst = 1'b0;
    @(negedge clk);
    tests++;
    if (out_valid !== 1'b0 || result !== '0 || mode_err !== 1'b0) begin
      fails++;
      $display("FAIL R1 after reset actual v=%b r=%h e=%b expected 0", out_valid, result, mode_err);
    end

    // directed corners, issued back to back
    issue(1, 2'b00, 2'b00, {112'h0, 16'h1234, 16'hFFFF}, 128'h1, "R4 add16 carry cut");
    issue(1, 2'b01, 2'b00, {64'h0, 32'h0000_0001, 32'hFFFF_FFFF}, {96'h0, 32'h1}, "R4 add32 carry cut");
    issue(1, 2'b10, 2'b00, {64'h5, 64'hFFFF_FFFF_FFFF_FFFF}, 128'h1, "R4 add64 carry cut");
    issue(1, 2'b00, 2'b01, {112'h0, 16'h0007, 16'h0000}, 128'h1, "R5 sub16 borrow cut");
    issue(1, 2'b10, 2'b01, {64'h9, 64'h0}, 128'h1, "R5 sub64 borrow cut");
    issue(1, 2'b00, 2'b10, {8{16'hFFFF}}, {8{16'hFFFF}}, "R6 mul16 max");
    issue(1, 2'b01, 2'b10, {4{32'h8000_0001}}, {4{32'h0001_0003}}, "R6 mul32");
    issue(1, 2'b10, 2'b10, {2{64'hFFFF_FFFF_FFFF_FFFF}}, {2{64'h3}}, "R6 mul64 max");
    issue(1, 2'b01, 2'b11, 128'hDEAD_BEEF_0123_4567_89AB_CDEF_F00D_CAFE, 128'h5, "R7 pass A");
    issue(1, 2'b11, 2'b00, {8{16'hFFFF}}, {8{16'h1}}, "R8 reserved width");
    issue(1, 2'b11, 2'b11, {8{16'hAAAA}}, '0, "R8 reserved width pass");
    issue(0, 2'b00, 2'b00, '0, '0, "R2 idle");
    issue(1, 2'b10, 2'b11, {4{32'h1357_9BDF}}, '0, "R7 pass A 64");

    // random stream with per-issue width and opcode changes
    for (int n = 0; n < 3000; n++) begin
      ra = {$urandom, $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom};
      if (($urandom % 4) == 0) rb = ~ra;
      issue((($urandom % 8) != 0), 2'($urandom), 2'($urandom), ra, rb, "R9 random R3 R5 R6");
    end
    issue(0, 2'b00, 2'b00, '0, '0, "R2 drain");
    issue(0, 2'b00, 2'b00, '0, '0, "R2 drain");
    issue(0, 2'b00, 2'b00, '0, '0, "R2 drain");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule